// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a controller that wants a flash operation done and the write path of an external parallel NOR flash. A single request names the operation, picks one of four bank bases, and supplies a target or block address and a data word. The block then issues the unlock and command words that the flash expects, one bus write at a time. Each write is held on a simple write-master port until the bus returns an acknowledge.

There are six operations: entering identifier mode, returning to read mode, programming one word, erasing one block, erasing the whole chip, and entering query mode. Command offsets are word offsets. When the memory is 16 bits wide, each offset is doubled before it is added to the bank base. The user address is added to the base as given. While a sequence runs, any new request is refused with a one-clock refusal flag. When the last write is acknowledged, a one-clock done pulse follows. Reading back identifier or query words, polling for completion and bus pin timing are handled elsewhere.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, busy, done, bus_we, req_accept and req_refused are all low while no request is presented.
- R2: Opcode 0 (identifier entry) issues three writes: 0xAA at command offset 0x555, then 0x55 at offset 0x2AA, then 0x90 at offset 0x555.
- R3: Opcode 2 (program) issues 0xAA at 0x555, 0x55 at 0x2AA and 0xA0 at 0x555. A fourth write then puts the request data word at bank base plus request address.
- R4: Opcode 4 (chip erase) issues six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555.
- R5: Opcode 3 (block erase) issues the same first five writes as chip erase. Its sixth write puts 0x30 at bank base plus request address.
- R6: Opcode 5 (query entry) issues exactly one write, 0x98 at command offset 0x055, with no unlock writes.
- R7: Opcode 1 (read reset) issues exactly one write, 0xF0, to the bank base address itself.
- R8: A command-offset address is base + offset when req_wide is 0 (8-bit memory) and base + (offset << 1) when req_wide is 1 (16-bit memory). The width is captured when the request is accepted. Command bytes appear zero-extended on bus_wdata.
- R9: req_bank values 0..3 select bank bases 0x000000, 0x400000, 0x800000 and 0xC00000 with the default parameters.
- R10: Each write keeps bus_we high, with bus_addr and bus_wdata unchanged, until a clock edge at which bus_ack is high. The next write, if any, appears in the following cycle.
- R11: A request made while busy makes req_refused high in that same cycle and req_accept low. The running sequence is left unchanged.
- R12: In the cycle after the last write is acknowledged, done is high for exactly one clock and busy is low. A new request can be accepted in that cycle.
- R13: Opcodes 6 and 7 are ignored when idle. Both req_accept and req_refused stay low and no write is issued.
- R14: A valid request while idle makes req_accept high in the same cycle. The first write is driven from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (0..5 valid) |
| req_bank | input | 2 | Bank base select |
| req_addr | input | ADDR_W | Target or block address, relative to bank base |
| req_data | input | DATA_W | Word to program |
| req_wide | input | 1 | 1: 16-bit memory, 0: 8-bit memory |
| req_accept | output | 1 | Request taken this cycle |
| req_refused | output | 1 | Request refused because busy |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock pulse after last write |
| bus_addr | output | ADDR_W | Write address |
| bus_wdata | output | DATA_W | Write data |
| bus_we | output | 1 | Write strobe, held until acknowledged |
| bus_ack | input | 1 | Write acknowledge |

## Verification
The bench builds the block with its default parameters: 24-bit addresses, 16-bit data and four bank bases spaced 4 MiB apart. With these values the doubled command offsets and the masked user addresses stay inside their bank, so a wrong bank choice or a missing shift shows up as a distinct address. Because the width is a request input, both the 8-bit and 16-bit address forms are reached in one build. Random acknowledge delays of zero to several cycles cover both back-to-back acknowledges and writes that are held for many cycles.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int CYC_MAX = 6;
    localparam int STEP_W  = $clog2(CYC_MAX);
    localparam int OFF_W   = 12;
    localparam int CODE_W  = 8;

    typedef enum logic [2:0] {
        OP_IDENT     = 3'd0,
        OP_READRST   = 3'd1,
        OP_PROG      = 3'd2,
        OP_BLKERASE  = 3'd3,
        OP_CHIPERASE = 3'd4,
        OP_QUERY     = 3'd5
    } nor_op_e;

    typedef enum logic [1:0] {
        SRC_CMD  = 2'd0,
        SRC_BASE = 2'd1,
        SRC_USER = 2'd2
    } addr_src_e;

    typedef struct packed {
        addr_src_e          src;
        logic [OFF_W-1:0]   off;
        logic               take_user;
        logic [CODE_W-1:0]  code;
    } bus_cyc_t;

    localparam logic [OFF_W-1:0] OFF_LONG  = 12'h555;
    localparam logic [OFF_W-1:0] OFF_SHORT = 12'h2AA;
    localparam logic [OFF_W-1:0] OFF_QRY   = 12'h055;

    function automatic bus_cyc_t mk_cyc(addr_src_e s, logic [OFF_W-1:0] o,
                                        logic u, logic [CODE_W-1:0] c);
        bus_cyc_t r;
        r.src       = s;
        r.off       = o;
        r.take_user = u;
        r.code      = c;
        return r;
    endfunction

    function automatic logic op_known(logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic [STEP_W-1:0] op_last_step(nor_op_e op);
        case (op)
            OP_IDENT:     return STEP_W'(2);
            OP_PROG:      return STEP_W'(3);
            OP_BLKERASE:  return STEP_W'(5);
            OP_CHIPERASE: return STEP_W'(5);
            default:      return STEP_W'(0);
        endcase
    endfunction

    // Command table: one entry per (operation, step)
    function automatic bus_cyc_t op_cycle(nor_op_e op, logic [STEP_W-1:0] step);
        bus_cyc_t c;
        c = mk_cyc(SRC_CMD, OFF_LONG, 1'b0, 8'hAA);
        case (op)
            OP_READRST: c = mk_cyc(SRC_BASE, '0, 1'b0, 8'hF0);
            OP_QUERY:   c = mk_cyc(SRC_CMD, OFF_QRY, 1'b0, 8'h98);
            default: begin
                if (step == STEP_W'(0)) begin
                    c = mk_cyc(SRC_CMD, OFF_LONG, 1'b0, 8'hAA);
                end else if (step == STEP_W'(1)) begin
                    c = mk_cyc(SRC_CMD, OFF_SHORT, 1'b0, 8'h55);
                end else begin
                    case (op)
                        OP_IDENT: c = mk_cyc(SRC_CMD, OFF_LONG, 1'b0, 8'h90);
                        OP_PROG: begin
                            if (step == STEP_W'(2))
                                c = mk_cyc(SRC_CMD, OFF_LONG, 1'b0, 8'hA0);
                            else
                                c = mk_cyc(SRC_USER, '0, 1'b1, 8'h00);
                        end
                        default: begin
                            case (step)
                                STEP_W'(2): c = mk_cyc(SRC_CMD, OFF_LONG, 1'b0, 8'h80);
                                STEP_W'(3): c = mk_cyc(SRC_CMD, OFF_LONG, 1'b0, 8'hAA);
                                STEP_W'(4): c = mk_cyc(SRC_CMD, OFF_SHORT, 1'b0, 8'h55);
                                default: begin
                                    if (op == OP_CHIPERASE)
                                        c = mk_cyc(SRC_CMD, OFF_LONG, 1'b0, 8'h10);
                                    else
                                        c = mk_cyc(SRC_USER, '0, 1'b0, 8'h30);
                                end
                            endcase
                        end
                    endcase
                end
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nor_bank_sel.sv
module nor_bank_sel #(
    parameter int ADDR_W    = 24,
    parameter int NUM_BANKS = 4,
    parameter logic [NUM_BANKS*ADDR_W-1:0] BANK_BASES = '0,
    localparam int SEL_W = $clog2(NUM_BANKS)
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] base
);
    logic [ADDR_W-1:0] bases [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_base
        assign bases[g] = BANK_BASES[g*ADDR_W +: ADDR_W];
    end

    assign base = bases[sel];
endmodule

// File: rtl/nor_addr_gen.sv
module nor_addr_gen
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  bus_cyc_t          cyc,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] user_addr,
    input  logic [DATA_W-1:0] user_data,
    input  logic              wide,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    logic [ADDR_W-1:0] off_scaled;

    assign off_scaled = ADDR_W'(cyc.off) << wide;

    always_comb begin
        case (cyc.src)
            SRC_CMD:  addr = base + off_scaled;
            SRC_BASE: addr = base;
            default:  addr = base + user_addr;
        endcase
        data = cyc.take_user ? user_data : DATA_W'(cyc.code);
    end
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  nor_op_e           start_op,
    input  logic              bus_ack,
    output logic              running,
    output nor_op_e           op_q,
    output logic [STEP_W-1:0] step_q,
    output logic              done
);
    typedef enum logic {S_IDLE, S_RUN} seq_st_e;
    seq_st_e st;

    assign running = (st == S_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            op_q   <= OP_READRST;
            step_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        op_q   <= start_op;
                        step_q <= '0;
                        st     <= S_RUN;
                    end
                end
                default: begin
                    if (bus_ack) begin
                        if (step_q == op_last_step(op_q)) begin
                            st   <= S_IDLE;
                            done <= 1'b1;
                        end else begin
                            step_q <= step_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 4,
    parameter logic [NUM_BANKS*ADDR_W-1:0] BANK_BASES =
        {24'hC00000, 24'h800000, 24'h400000, 24'h000000},
    localparam int BSEL_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [BSEL_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_wide,
    output logic              req_accept,
    output logic              req_refused,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    input  logic              bus_ack
);
    logic              running;
    nor_op_e           op_q;
    logic [STEP_W-1:0] step_q;
    logic [ADDR_W-1:0] sel_base;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              wide_q;
    bus_cyc_t          cur_cyc;

    assign req_accept  = req_valid && !running && op_known(req_op);
    assign req_refused = req_valid && running;
    assign busy        = running;
    assign bus_we      = running;

    nor_bank_sel #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS),
        .BANK_BASES(BANK_BASES)
    ) u_bank (
        .sel (req_bank),
        .base(sel_base)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            addr_q <= '0;
            data_q <= '0;
            wide_q <= 1'b0;
        end else if (req_accept) begin
            base_q <= sel_base;
            addr_q <= req_addr;
            data_q <= req_data;
            wide_q <= req_wide;
        end
    end

    nor_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (req_accept),
        .start_op(nor_op_e'(req_op)),
        .bus_ack (bus_ack),
        .running (running),
        .op_q    (op_q),
        .step_q  (step_q),
        .done    (done)
    );

    assign cur_cyc = op_cycle(op_q, step_q);

    nor_addr_gen #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_agen (
        .cyc      (cur_cyc),
        .base     (base_q),
        .user_addr(addr_q),
        .user_data(data_q),
        .wide     (wide_q),
        .addr     (bus_addr),
        .data     (bus_wdata)
    );
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic              req_accept,
    input logic              req_refused,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              bus_ack
);
    // R10
    hold_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        bus_we && !bus_ack |=> bus_we && $stable(bus_addr) && $stable(bus_wdata));

    // R11
    refuse_keep_chk: assert property (@(posedge clk) disable iff (rst)
        req_refused && !bus_ack |=> busy && $stable(bus_addr) && $stable(bus_wdata));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_we && bus_ack) && !busy);

    // R14
    accept_start_chk: assert property (@(posedge clk) disable iff (rst)
        req_accept |=> bus_we);

    // R13
    unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy && (req_op > 3'd5) |=> !bus_we);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_accept (req_accept),
    .req_refused(req_refused),
    .busy       (busy),
    .done       (done),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_ack    (bus_ack)
);

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_bank = '0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic        req_wide = 1'b0;
    logic        req_accept, req_refused, busy, done, bus_we;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    logic [23:0] exp_a [0:7];
    logic [15:0] exp_d [0:7];
    int exp_n = 0;
    int idx = 0;
    string cur_tag = "R2";
    int ack_wait_max = 0;
    int wait_cnt = 0;
    logic held = 1'b0;
    logic [23:0] prev_a = '0;
    logic [15:0] prev_d = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_seq u_nor_cmd_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_addr(req_addr), .req_data(req_data),
        .req_wide(req_wide), .req_accept(req_accept), .req_refused(req_refused),
        .busy(busy), .done(done), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_ack(bus_ack)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [23:0] bank_base(logic [1:0] b);
        return {b, 22'h0};
    endfunction

    function automatic logic [23:0] cmd_at(logic [1:0] b, logic [11:0] off, logic w);
        return bank_base(b) + (w ? {11'h0, off, 1'b0} : {12'h0, off});
    endfunction

    task automatic push(logic [23:0] a, logic [15:0] d);
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_n++;
    endtask

    task automatic build_expect(logic [2:0] op, logic [1:0] b, logic [23:0] a,
                                logic [15:0] d, logic w);
        exp_n = 0;
        case (op)
            3'd1: push(bank_base(b), 16'h00F0);
            3'd5: push(cmd_at(b, 12'h055, w), 16'h0098);
            default: begin
                push(cmd_at(b, 12'h555, w), 16'h00AA);
                push(cmd_at(b, 12'h2AA, w), 16'h0055);
                if (op == 3'd0) push(cmd_at(b, 12'h555, w), 16'h0090);
                if (op == 3'd2) begin
                    push(cmd_at(b, 12'h555, w), 16'h00A0);
                    push(bank_base(b) + a, d);
                end
                if (op == 3'd3 || op == 3'd4) begin
                    push(cmd_at(b, 12'h555, w), 16'h0080);
                    push(cmd_at(b, 12'h555, w), 16'h00AA);
                    push(cmd_at(b, 12'h2AA, w), 16'h0055);
                    if (op == 3'd4) push(cmd_at(b, 12'h555, w), 16'h0010);
                    else            push(bank_base(b) + a, 16'h0030);
                end
            end
        endcase
    endtask

    function automatic string tag_of(logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R7";
            3'd2: return "R3";
            3'd3: return "R5";
            3'd4: return "R4";
            default: return "R6";
        endcase
    endfunction

    // Bus responder: checks every write and acknowledges after a random wait
    always @(negedge clk) begin
        if (rst) begin
            bus_ack <= 1'b0;
            held = 1'b0;
        end else begin
            if (held && bus_we) begin
                chk("R10", "held addr", 32'(bus_addr), 32'(prev_a));
                chk("R10", "held data", 32'(bus_wdata), 32'(prev_d));
            end
            if (bus_we) begin
                if (wait_cnt == 0) begin
                    if (idx < exp_n) begin
                        chk(cur_tag, "write addr", 32'(bus_addr), 32'(exp_a[idx]));
                        chk(cur_tag, "write data", 32'(bus_wdata), 32'(exp_d[idx]));
                    end else begin
                        chk(cur_tag, "extra write", 32'(idx), 32'(exp_n));
                    end
                    idx++;
                    bus_ack <= 1'b1;
                    held = 1'b0;
                    wait_cnt = $urandom_range(0, ack_wait_max);
                end else begin
                    wait_cnt--;
                    bus_ack <= 1'b0;
                    held = 1'b1;
                    prev_a = bus_addr;
                    prev_d = bus_wdata;
                end
            end else begin
                bus_ack <= 1'b0;
                held = 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc_cnt);
            report();
        end
    end

    // Called at a negedge with the block idle
    task automatic run_op(logic [2:0] op, logic [1:0] b, logic [23:0] a,
                          logic [15:0] d, logic w, bit inject, bit chain);
        int guard;
        build_expect(op, b, a, d, w);
        idx = 0;
        cur_tag = tag_of(op);
        wait_cnt = $urandom_range(0, ack_wait_max);
        req_valid = 1'b1; req_op = op; req_bank = b;
        req_addr = a; req_data = d; req_wide = w;
        #1;
        chk("R14", "accept when idle", 32'(req_accept), 32'd1);
        chk("R14", "no refusal when idle", 32'(req_refused), 32'd0);
        @(negedge clk);
        if (inject) begin
            req_op = 3'd4; req_bank = ~b; req_addr = ~a; req_wide = ~w;
            #1;
            chk("R11", "refused while busy", 32'(req_refused), 32'd1);
            chk("R11", "not accepted while busy", 32'(req_accept), 32'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        chk("R12", "done seen", 32'(done), 32'd1);
        chk("R12", "idle during done", 32'(busy), 32'd0);
        chk(cur_tag, "write count", 32'(idx), 32'(exp_n));
        if (!chain) begin
            @(negedge clk);
            chk("R12", "done one clock", 32'(done), 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "bus_we", 32'(bus_we), 32'd0);
        chk("R1", "accept", 32'(req_accept), 32'd0);
        chk("R1", "refused", 32'(req_refused), 32'd0);

        // Directed: each operation, both widths, banks R9
        ack_wait_max = 0;
        run_op(3'd0, 2'd0, 24'h0, 16'h0, 1'b0, 0, 0);          // R2 8-bit
        run_op(3'd0, 2'd1, 24'h0, 16'h0, 1'b1, 0, 0);          // R2 R8 16-bit
        run_op(3'd1, 2'd2, 24'h0, 16'h0, 1'b1, 0, 0);          // R7 R9
        run_op(3'd2, 2'd3, 24'h012346, 16'hBEEF, 1'b1, 0, 0);  // R3 R9
        ack_wait_max = 4;
        run_op(3'd3, 2'd1, 24'h020000, 16'h0, 1'b0, 0, 0);     // R5
        run_op(3'd4, 2'd2, 24'h0, 16'h0, 1'b1, 0, 0);          // R4 R8
        run_op(3'd5, 2'd3, 24'h0, 16'h0, 1'b0, 0, 0);          // R6
        run_op(3'd5, 2'd0, 24'h0, 16'h0, 1'b1, 0, 0);          // R6 R8
        // R11 refusal during short and long sequences
        ack_wait_max = 0;
        run_op(3'd1, 2'd0, 24'h0, 16'h0, 1'b0, 1, 0);
        ack_wait_max = 3;
        run_op(3'd2, 2'd1, 24'h000100, 16'h1234, 1'b0, 1, 0);
        // R12 back-to-back: next request in the done cycle
        run_op(3'd0, 2'd2, 24'h0, 16'h0, 1'b0, 0, 1);
        run_op(3'd4, 2'd3, 24'h0, 16'h0, 1'b0, 0, 0);
        // R13 unknown opcodes ignored
        for (int k = 6; k < 8; k++) begin
            req_valid = 1'b1; req_op = 3'(k);
            #1;
            chk("R13", "no accept", 32'(req_accept), 32'd0);
            chk("R13", "no refusal", 32'(req_refused), 32'd0);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R13", "no write", 32'(bus_we), 32'd0);
            chk("R13", "not busy", 32'(busy), 32'd0);
            @(negedge clk);
            chk("R13", "still no write", 32'(bus_we), 32'd0);
        end

        // Random mix
        for (int n = 0; n < 60; n++) begin
            ack_wait_max = $urandom_range(0, 3);
            run_op(3'($urandom_range(0, 5)), 2'($urandom_range(0, 3)),
                   24'($urandom) & 24'h0FFFFF, 16'($urandom), 1'($urandom),
                   (n % 5) == 0, (n % 7) == 3);
        end
        @(negedge clk);
        report();
    end
endmodule